// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Flag-Holding Status Register

This block combines an 8-bit combinational arithmetic/logic unit with an 8-bit status register. The status register holds four condition flags and two 2-bit mode fields that select how two address pointers behave. Each operation takes a working-register operand and a second operand. The second operand is a file-register value or an immediate; single-operand operations use only the second operand. The result appears in the same cycle. The flags that the operation affects are captured on the clock edge that ends that cycle.

The status register can also be the destination of an operation. When that operation also produces Z, DC or C, the flag logic owns all four flag bits and the result reaches only the mode fields. A stored value can therefore differ from the computed result. Operations that touch no flag write the whole word. A separate register-file write port loads the full word when no operation is issued.

Top module: `alu_sts_unit`

## Requirements
- R1: Status layout, from bit 7 down to bit 0: pointer-1 mode [7:6], pointer-0 mode [5:4], OV [3], Z [2], DC [1], C [0]. Reset is asserted asynchronously through the active-low `rst_n` and released on the second clock edge after `rst_n` rises. While reset is active, bits [7:4] read 1. The flag bits are not initialised.
- R2: Opcode 0 (add) gives result = opnd_in + wreg_in mod 256. C is the carry out of bit 7, DC is the carry out of bit 3, OV is set when the signed sum lies outside -128..+127, and Z is set when the result is zero.
- R3: Opcode 1 (subtract) gives result = opnd_in - wreg_in, computed as opnd_in + ~wreg_in + 1. C and DC are 1 when bit 7 (for C) or bit 3 (for DC) needs no borrow. OV is set when the signed difference lies outside -128..+127. Z is set when the result is zero.
- R4: Opcodes 2, 3 and 4 (AND, OR, XOR of the two operands) update Z only. OV, DC and C keep their values.
- R5: Opcode 5 rotates opnd_in right through C, and C takes bit 0. Opcode 6 rotates opnd_in left through C, and C takes bit 7. OV, Z and DC keep their values.
- R6: Opcode 7 (clear) gives result 0 and sets Z. With the status register as destination, the stored word is 0000u1uu, where u means the bit keeps its old value.
- R7: Opcodes 8 (nibble swap of opnd_in), 9 (pass wreg_in), 10 (set bit bit_sel of opnd_in) and 11 (clear bit bit_sel of opnd_in) change no flag. With the status register as destination, they store the whole result.
- R8: When the status register is the destination of an operation that affects Z, DC or C, result bits [7:4] go to the mode fields. The result's bits [3:0] are ignored: each flag takes its computed value if the operation affects it, and otherwise keeps its old value.
- R9: Flags update on the clock edge that ends the operation cycle, while `result` is valid in that cycle. `sts_wr_en` loads all 8 bits of `sts_wr_data` only when `op_valid` is low; an issued operation takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op | input | 4 | Opcode (see R2 to R7) |
| wreg_in | input | 8 | Working-register operand |
| opnd_in | input | 8 | File-register or immediate operand |
| bit_sel | input | 3 | Bit index for bit set/clear |
| dst_status | input | 1 | The issued operation targets the status register |
| sts_wr_en | input | 1 | Register-file write strobe for the status word |
| sts_wr_data | input | 8 | Register-file write data for the status word |
| result | output | 8 | Combinational operation result |
| status_q | output | 8 | Status register contents |

## Verification
The bench builds the block with its defaults: an 8-bit data path and a two-stage reset release. At this width, random operands regularly hit the nibble-carry, carry, signed-overflow and zero boundaries. Directed cases pin the exact edges 0x7F+1, 0x0F+1, 0-1 and 0xFF+1. Destination-is-status operations are mixed with concurrent register-file writes, so the masking of the flag bits and the priority of an issued operation over a write are both exercised.

// File: rtl/alu_sts_pkg.sv
package alu_sts_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_IOR  = 4'd3,
    OP_XOR  = 4'd4,
    OP_RRC  = 4'd5,
    OP_RLC  = 4'd6,
    OP_CLR  = 4'd7,
    OP_SWAP = 4'd8,
    OP_MOV  = 4'd9,
    OP_BSET = 4'd10,
    OP_BCLR = 4'd11
  } op_e;

  typedef struct packed {
    logic ov;
    logic z;
    logic dc;
    logic c;
  } flags_t;

  localparam int FLAG_W = 4;
endpackage

// File: rtl/alu_sts_rst_sync.sv
module alu_sts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/alu_sts_core.sv
module alu_sts_core
  import alu_sts_pkg::*;
#(
  parameter int W = 8,
  localparam int HALF = W / 2,
  localparam int BW = $clog2(W)
) (
  input  logic [3:0]    op,
  input  logic [W-1:0]  wreg_in,
  input  logic [W-1:0]  opnd_in,
  input  logic [BW-1:0] bit_sel,
  input  logic          c_in,
  output logic [W-1:0]  result,
  output flags_t        flag_new,
  output flags_t        flag_upd
);
  logic          is_sub;
  logic [W-1:0]  b_eff;
  logic [W:0]    full_sum;
  logic [HALF:0] low_sum;
  logic [W-1:0]  bit_mask;

  assign is_sub   = (op == OP_SUB);
  assign b_eff    = is_sub ? ~wreg_in : wreg_in;
  assign full_sum = {1'b0, opnd_in} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
  assign low_sum  = {1'b0, opnd_in[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]}
                  + {{HALF{1'b0}}, is_sub};
  assign bit_mask = {{(W-1){1'b0}}, 1'b1} << bit_sel;

  always_comb begin
    result   = opnd_in;
    flag_new = '0;
    flag_upd = '0;
    unique case (op_e'(op))
      OP_ADD, OP_SUB: begin
        result      = full_sum[W-1:0];
        flag_new.c  = full_sum[W];
        flag_new.dc = low_sum[HALF];
        flag_new.ov = (opnd_in[W-1] == b_eff[W-1]) && (full_sum[W-1] != opnd_in[W-1]);
        flag_upd    = '1;
      end
      OP_AND: begin result = opnd_in & wreg_in; flag_upd.z = 1'b1; end
      OP_IOR: begin result = opnd_in | wreg_in; flag_upd.z = 1'b1; end
      OP_XOR: begin result = opnd_in ^ wreg_in; flag_upd.z = 1'b1; end
      OP_RRC: begin
        result     = {c_in, opnd_in[W-1:1]};
        flag_new.c = opnd_in[0];
        flag_upd.c = 1'b1;
      end
      OP_RLC: begin
        result     = {opnd_in[W-2:0], c_in};
        flag_new.c = opnd_in[W-1];
        flag_upd.c = 1'b1;
      end
      OP_CLR:  begin result = '0; flag_upd.z = 1'b1; end
      OP_SWAP: result = {opnd_in[HALF-1:0], opnd_in[W-1:HALF]};
      OP_MOV:  result = wreg_in;
      OP_BSET: result = opnd_in | bit_mask;
      OP_BCLR: result = opnd_in & ~bit_mask;
      default: result = opnd_in;
    endcase
    flag_new.z = (result == '0);
  end
endmodule

// File: rtl/alu_sts_reg.sv
module alu_sts_reg
  import alu_sts_pkg::*;
#(
  parameter int W = 8,
  localparam int MODE_W = W - FLAG_W
) (
  input  logic         clk,
  input  logic         rst_sync_n,
  input  logic         op_valid,
  input  logic         dst_status,
  input  logic [W-1:0] result,
  input  flags_t       flag_new,
  input  flags_t       flag_upd,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] status_q
);
  logic [MODE_W-1:0] mode_q, mode_nxt;
  flags_t            flag_q, flag_nxt;
  logic              mode_en, flag_en, protect;

  assign protect = flag_upd.z | flag_upd.dc | flag_upd.c;

  always_comb begin
    mode_nxt = mode_q;
    flag_nxt = flag_q;
    mode_en  = 1'b0;
    flag_en  = 1'b0;
    if (op_valid) begin
      flag_en = 1'b1;
      if (dst_status) begin
        mode_en  = 1'b1;
        mode_nxt = result[W-1:FLAG_W];
      end
      if (dst_status && !protect) begin
        flag_nxt = flags_t'(result[FLAG_W-1:0]);
      end else begin
        flag_nxt.ov = flag_upd.ov ? flag_new.ov : flag_q.ov;
        flag_nxt.z  = flag_upd.z  ? flag_new.z  : flag_q.z;
        flag_nxt.dc = flag_upd.dc ? flag_new.dc : flag_q.dc;
        flag_nxt.c  = flag_upd.c  ? flag_new.c  : flag_q.c;
      end
    end else if (wr_en) begin
      mode_en  = 1'b1;
      flag_en  = 1'b1;
      mode_nxt = wr_data[W-1:FLAG_W];
      flag_nxt = flags_t'(wr_data[FLAG_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mode_q <= '1;
    else if (mode_en) mode_q <= mode_nxt;
  end

  always_ff @(posedge clk) begin
    if (flag_en) flag_q <= flag_nxt;
  end

  assign status_q = {mode_q, flag_q};
endmodule

// File: rtl/alu_sts_unit.sv
module alu_sts_unit
  import alu_sts_pkg::*;
#(
  parameter int W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int BW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op,
  input  logic [W-1:0]  wreg_in,
  input  logic [W-1:0]  opnd_in,
  input  logic [BW-1:0] bit_sel,
  input  logic          dst_status,
  input  logic          sts_wr_en,
  input  logic [W-1:0]  sts_wr_data,
  output logic [W-1:0]  result,
  output logic [W-1:0]  status_q
);
  logic   rst_sync_n;
  flags_t flag_new, flag_upd;

  alu_sts_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  alu_sts_core #(.W(W)) u_core (
    .op(op), .wreg_in(wreg_in), .opnd_in(opnd_in), .bit_sel(bit_sel),
    .c_in(status_q[0]), .result(result), .flag_new(flag_new), .flag_upd(flag_upd)
  );

  alu_sts_reg #(.W(W)) u_reg (
    .clk(clk), .rst_sync_n(rst_sync_n), .op_valid(op_valid), .dst_status(dst_status),
    .result(result), .flag_new(flag_new), .flag_upd(flag_upd),
    .wr_en(sts_wr_en), .wr_data(sts_wr_data), .status_q(status_q)
  );
endmodule

// File: rtl/alu_sts_unit_chk.sv
module alu_sts_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         op_valid,
  input logic [3:0]   op,
  input logic         dst_status,
  input logic [W-1:0] wreg_in,
  input logic [W-1:0] opnd_in,
  input logic [W-1:0] result,
  input logic [W-1:0] status_q
);
  logic [W:0] plain_add;
  logic       is_logic, no_flag, go_flags;
  assign plain_add = {1'b0, opnd_in} + {1'b0, wreg_in};
  assign is_logic  = (op == 4'd2) || (op == 4'd3) || (op == 4'd4);
  assign no_flag   = (op >= 4'd8) && (op <= 4'd11);
  assign go_flags  = op_valid && !dst_status;

  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    go_flags && op == 4'd0 |=> status_q[0] == $past(plain_add[W])); // R2

  AST_LOGIC_KEEPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    go_flags && is_logic |=> status_q[3] == $past(status_q[3]) && status_q[1:0] == $past(status_q[1:0])
      && status_q[2] == ($past(result) == '0)); // R4

  AST_RRC_CARRY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    go_flags && op == 4'd5 |=> status_q[0] == $past(opnd_in[0])); // R5

  AST_CLR_STATUS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && dst_status && op == 4'd7 |=> status_q[W-1:4] == '0 && status_q[2]
      && status_q[3] == $past(status_q[3]) && status_q[1:0] == $past(status_q[1:0])); // R6

  AST_NOFLAG_FULL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && dst_status && no_flag |=> status_q == $past(result)); // R7

  AST_OP_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && !dst_status && no_flag |=> status_q == $past(status_q)); // R9
endmodule

bind alu_sts_unit alu_sts_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .op_valid(op_valid), .op(op),
  .dst_status(dst_status), .wreg_in(wreg_in), .opnd_in(opnd_in),
  .result(result), .status_q(status_q)
);

// File: tb/alu_sts_unit_bench.sv
module alu_sts_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid, dst_status, sts_wr_en;
  logic [3:0] op;
  logic [7:0] wreg_in, opnd_in, sts_wr_data, result, status_q;
  logic [2:0] bit_sel;
  logic [7:0] exp_sts;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  alu_sts_unit u_alu_sts_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .wreg_in(wreg_in),
    .opnd_in(opnd_in), .bit_sel(bit_sel), .dst_status(dst_status),
    .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .result(result), .status_q(status_q)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R2 add";
      4'd1: return "R3 sub";
      4'd2, 4'd3, 4'd4: return "R4 logic";
      4'd5, 4'd6: return "R5 rotate";
      4'd7: return "R6 clear";
      default: return "R7 noflag";
    endcase
  endfunction

  // returns {result, next status}
  function automatic logic [15:0] model(input logic [3:0] o, input logic [7:0] w, f,
                                        input logic [2:0] bs, input logic dst, input logic [7:0] s);
    int sum, ss;
    logic [7:0] r, n;
    logic c, dc, z, ov, touched;
    c = s[0]; dc = s[1]; z = s[2]; ov = s[3]; r = f; touched = 1'b0;
    case (o)
      4'd0: begin
        sum = int'(f) + int'(w); r = sum[7:0]; c = sum > 255;
        dc = (int'(f % 16) + int'(w % 16)) > 15;
        ss = int'($signed(f)) + int'($signed(w)); ov = (ss > 127) || (ss < -128);
        z = (r == 0); touched = 1'b1;
      end
      4'd1: begin
        sum = int'(f) - int'(w); r = sum[7:0]; c = sum >= 0;
        dc = (f % 16) >= (w % 16);
        ss = int'($signed(f)) - int'($signed(w)); ov = (ss > 127) || (ss < -128);
        z = (r == 0); touched = 1'b1;
      end
      4'd2: begin r = f & w; z = (r == 0); touched = 1'b1; end
      4'd3: begin r = f | w; z = (r == 0); touched = 1'b1; end
      4'd4: begin r = f ^ w; z = (r == 0); touched = 1'b1; end
      4'd5: begin r = {s[0], f[7:1]}; c = f[0]; touched = 1'b1; end
      4'd6: begin r = {f[6:0], s[0]}; c = f[7]; touched = 1'b1; end
      4'd7: begin r = 8'h00; z = 1'b1; touched = 1'b1; end
      4'd8: r = {f[3:0], f[7:4]};
      4'd9: r = w;
      4'd10: begin r = f; r[bs] = 1'b1; end
      4'd11: begin r = f; r[bs] = 1'b0; end
      default: r = f;
    endcase
    if (dst && touched)      n = {r[7:4], ov, z, dc, c};
    else if (dst)            n = r;
    else                     n = {s[7:4], ov, z, dc, c};
    return {r, n};
  endfunction

  task automatic step(input logic v, input logic [3:0] o, input logic [7:0] w, f,
                      input logic [2:0] bs, input logic dst, input logic we, input logic [7:0] wd,
                      input string tag);
    logic [15:0] e;
    e = model(o, w, f, bs, dst, exp_sts);
    @(negedge clk);
    op_valid = v; op = o; wreg_in = w; opnd_in = f; bit_sel = bs;
    dst_status = dst; sts_wr_en = we; sts_wr_data = wd;
    #1;
    if (v) check({tag, " R9 result"}, result, e[15:8]);
    @(posedge clk); #1;
    if (v)       exp_sts = e[7:0];
    else if (we) exp_sts = wd;
    check({tag, " status"}, status_q, exp_sts);
    op_valid = 0; sts_wr_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] ro;
    void'($urandom(32'd5150));
    rst_n = 0; op_valid = 0; op = 0; wreg_in = 0; opnd_in = 0; bit_sel = 0;
    dst_status = 0; sts_wr_en = 0; sts_wr_data = 0;
    repeat (3) @(posedge clk);
    #1 check("R1 mode bits in reset", {status_q[7:4], 4'h0}, 8'hF0);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    #1 check("R1 mode bits after release", {status_q[7:4], 4'h0}, 8'hF0);
    exp_sts = 8'hF0;
    // R9 write port
    step(0, 4'd0, 8'h00, 8'h00, 3'd0, 0, 1, 8'h5A, "R9 write");
    step(0, 4'd0, 8'h00, 8'h00, 3'd0, 0, 1, 8'hC0, "R9 write");
    // R2 boundaries
    step(1, 4'd0, 8'h01, 8'h7F, 3'd0, 0, 0, 8'h00, "R2 ov");
    step(1, 4'd0, 8'h01, 8'h0F, 3'd0, 0, 0, 8'h00, "R2 dc");
    step(1, 4'd0, 8'h01, 8'hFF, 3'd0, 0, 0, 8'h00, "R2 carry zero");
    // R3 boundaries
    step(1, 4'd1, 8'h01, 8'h00, 3'd0, 0, 0, 8'h00, "R3 borrow");
    step(1, 4'd1, 8'h01, 8'h80, 3'd0, 0, 0, 8'h00, "R3 ov");
    step(1, 4'd1, 8'h33, 8'h33, 3'd0, 0, 0, 8'h00, "R3 equal");
    // R5 rotates
    step(1, 4'd5, 8'h00, 8'h01, 3'd0, 0, 0, 8'h00, "R5 rrc");
    step(1, 4'd6, 8'h00, 8'h40, 3'd0, 0, 0, 8'h00, "R5 rlc");
    // R6 clear into status, then R8 add into status, R7 move into status
    step(0, 4'd0, 8'h00, 8'h00, 3'd0, 0, 1, 8'hFB, "R9 write");
    step(1, 4'd7, 8'h00, 8'hFF, 3'd0, 1, 0, 8'h00, "R6 clr status");
    step(1, 4'd0, 8'h10, 8'h4F, 3'd0, 1, 0, 8'h00, "R8 add to status");
    step(1, 4'd9, 8'hA5, 8'h00, 3'd0, 1, 0, 8'h00, "R7 mov to status");
    step(1, 4'd10, 8'h00, 8'h20, 3'd3, 1, 0, 8'h00, "R7 bset to status");
    // R9 priority of op over write
    step(1, 4'd8, 8'h00, 8'h3C, 3'd0, 0, 1, 8'h00, "R9 priority");
    // random mix
    for (int i = 0; i < 600; i++) begin
      ro = 4'($urandom_range(0, 11));
      step($urandom_range(0, 7) != 0, ro, 8'($urandom), 8'($urandom), 3'($urandom),
           $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, 8'($urandom),
           {tag_of(ro), " R8 random"});
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule